// File: doc/BRIEF.md
# RF Filter Configuration Sequencer

This block drives a receive-path RF filter through its ASCII command protocol. It sits above a serial transaction engine. For each step it builds a fixed-size command buffer, hands the buffer to the engine with a one-cycle start strobe, and waits for the engine to return the first reply character and the decimal value it parsed from the reply. Each step has its own acceptance rule. The block then moves on to the next step or ends the sequence, and it reports a done pulse, a pass flag and the code of the first step that failed.

Three operations can be requested while the block is idle:
- tune: the enable chain (bandwidth, two arming letters, frequency) followed by a status query;
- status: the status query alone;
- disable: the shutdown command.

The disable operation also runs by itself once after reset. Numeric arguments are turned into fixed-width, zero-padded ASCII decimal by a sequential divide-by-ten unit.

Top module: `rfc_cfg_seq`

## Requirements
- R1: A requested bandwidth of 5, 10, 20 or 40 is used as given. Any other value, including 0, is replaced by 20 before it is formatted and compared.
- R2: The first tune step sends `b` followed by the bandwidth as two zero-padded ASCII decimal digits. It is accepted only when the reply character is `B` and the reply value equals the bandwidth in use.
- R3: After an accepted bandwidth step, a lone `x` is sent and a reply of `X` is required. After that, a lone `m` is sent and a reply of `M` is required.
- R4: The last enable step sends `f` followed by the frequency as five zero-padded ASCII decimal digits. It fails only when the reply character is not `F` and the reply value also differs from the frequency.
- R5: The enable chain stops at its first failing step, and no later enable step is issued. A tune operation always ends with the status query, whether the enable chain failed or not.
- R6: Disable sends the three bytes `b`,`4`,`0`. It is accepted when the reply character is `B` and the reply value is greater than zero.
- R7: Status sends a lone `s` and is accepted when the reply character is `S`.
- R8: After reset, a disable sequence starts without any request, and `op_ready` stays low until it completes.
- R9: `txn_cmd` holds 10 bytes. Byte 0 (bits 7:0) is sent first, and every byte after the command's text is zero. `txn_start` is high for exactly one cycle per command, and `txn_cmd` does not change until `txn_done`.
- R10: Operation codes are: 0 = tune, 1 = status, 2 = disable. A request is taken only when `op_valid` and `op_ready` are both high. Code 3 and requests made while busy are ignored.
- R11: At the end of a sequence `seq_done` pulses for one cycle. `seq_pass` is high only if every step was accepted, and `fail_step` holds the first rejected step. Step codes are: 0 = none, 1 = bandwidth, 2 = `x`, 3 = `m`, 4 = frequency, 5 = status, 6 = disable. `step_idx` shows the step in progress and is 0 when idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation request |
| op_code | input | 2 | Operation selector (R10) |
| bw_mhz | input | 8 | Requested bandwidth in MHz |
| freq_mhz | input | FREQ_W | Centre frequency in MHz |
| op_ready | output | 1 | Idle and able to take a request |
| txn_start | output | 1 | Start strobe to the transaction engine |
| txn_cmd | output | CMD_BYTES*8 | Command buffer, byte 0 in the low bits |
| txn_done | input | 1 | Transaction finished, reply fields valid |
| rsp_char | input | 8 | First reply character |
| rsp_val | input | VAL_W | Decimal value parsed from the reply |
| seq_done | output | 1 | One-cycle end-of-sequence pulse |
| seq_pass | output | 1 | Sequence outcome |
| step_idx | output | 3 | Step in progress |
| fail_step | output | 3 | First rejected step |

## Verification
The bench builds the block with its default parameters: a 17-bit frequency, a 20-bit reply value, a 10-byte buffer and five frequency digits. With these values the widest frequency, 99999, is formatted with all five digits non-zero. Padding can be seen past both a two-digit and a five-digit argument. A bench-side responder echoes each command and can corrupt the character, the value or both at a chosen step. This reaches every acceptance rule, including the weak frequency rule and the abort-then-status ordering.

// File: rtl/rfc_pkg.sv
package rfc_pkg;

    localparam int BW_W = 8;

    typedef enum logic [2:0] {
        STP_NONE = 3'd0,
        STP_BW   = 3'd1,
        STP_XC   = 3'd2,
        STP_MC   = 3'd3,
        STP_FQ   = 3'd4,
        STP_STAT = 3'd5,
        STP_DIS  = 3'd6
    } step_e;

    typedef enum logic [1:0] {
        OPC_TUNE    = 2'd0,
        OPC_STATUS  = 2'd1,
        OPC_DISABLE = 2'd2,
        OPC_RSVD    = 2'd3
    } opc_e;

    typedef enum logic [2:0] {
        FS_BOOT,
        FS_IDLE,
        FS_PREP,
        FS_CONV,
        FS_ISSUE,
        FS_WAIT
    } fsm_e;

    // lower-case letter that opens the command of a step
    function automatic logic [7:0] cmd_letter(input step_e s);
        case (s)
            STP_BW, STP_DIS: return 8'h62;   // b
            STP_XC:          return 8'h78;   // x
            STP_MC:          return 8'h6d;   // m
            STP_FQ:          return 8'h66;   // f
            STP_STAT:        return 8'h73;   // s
            default:         return 8'h00;
        endcase
    endfunction

    // the filter answers with the upper-case form of the command letter
    function automatic logic [7:0] reply_letter(input step_e s);
        logic [7:0] c;
        c = cmd_letter(s);
        return (c == 8'h00) ? 8'h00 : (c - 8'h20);
    endfunction

    function automatic logic [BW_W-1:0] bw_fix(input logic [BW_W-1:0] bw);
        case (bw)
            BW_W'(5), BW_W'(10), BW_W'(20), BW_W'(40): return bw;
            default:                                   return BW_W'(20);
        endcase
    endfunction

endpackage

// File: rtl/rfc_dec_ascii.sv
// Sequential binary to fixed-width ASCII decimal, one digit per cycle,
// least significant digit first. asc[8*j +: 8] is digit j, j = 0 most significant.
module rfc_dec_ascii #(
    parameter int VW   = 17,
    parameter int NDIG = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [VW-1:0]     value,
    output logic              done,
    output logic [NDIG*8-1:0] asc
);
    localparam int CW = $clog2(NDIG);

    logic [VW-1:0] rem;
    logic [VW-1:0] q10;
    logic [VW-1:0] r10;
    logic [CW-1:0] cnt;
    logic [CW-1:0] slot;
    logic          busy;
    logic [7:0]    asc_a [NDIG];

    always_comb begin
        q10  = rem / VW'(10);
        r10  = rem % VW'(10);
        slot = CW'(NDIG - 1) - cnt;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rem  <= '0;
            cnt  <= '0;
            busy <= 1'b0;
            done <= 1'b0;
            for (int j = 0; j < NDIG; j++) asc_a[j] <= 8'h30;
        end else begin
            done <= 1'b0;
            if (start) begin
                rem  <= value;
                cnt  <= '0;
                busy <= 1'b1;
            end else if (busy) begin
                asc_a[slot] <= 8'(r10) + 8'h30;
                rem         <= q10;
                cnt         <= cnt + CW'(1);
                if (cnt == CW'(NDIG - 1)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    for (genvar j = 0; j < NDIG; j++) begin : g_pack
        assign asc[8*j +: 8] = asc_a[j];
    end

endmodule

// File: rtl/rfc_cmd_build.sv
// Assembles the zero-padded command buffer for one step.
module rfc_cmd_build import rfc_pkg::*; #(
    parameter int NB   = 10,
    parameter int NDIG = 5
) (
    input  step_e             step,
    input  logic [NDIG*8-1:0] asc,
    output logic [NB*8-1:0]   cmd
);
    always_comb begin
        cmd       = '0;
        cmd[7:0]  = cmd_letter(step);
        case (step)
            STP_BW: begin
                cmd[15:8]  = asc[8*(NDIG-2) +: 8];
                cmd[23:16] = asc[8*(NDIG-1) +: 8];
            end
            STP_FQ: begin
                for (int j = 0; j < NDIG; j++) cmd[8*(j+1) +: 8] = asc[8*j +: 8];
            end
            STP_DIS: begin
                cmd[15:8]  = 8'h34;
                cmd[23:16] = 8'h30;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/rfc_reply_judge.sv
// Per-step acceptance rule applied to the reply.
module rfc_reply_judge import rfc_pkg::*; #(
    parameter int VW = 20,
    parameter int FW = 17
) (
    input  step_e           step,
    input  logic [7:0]      rsp_char,
    input  logic [VW-1:0]   rsp_val,
    input  logic [BW_W-1:0] bw,
    input  logic [FW-1:0]   freq,
    output logic            ok
);
    logic ch_ok;
    always_comb begin
        ch_ok = (rsp_char == reply_letter(step));
        case (step)
            STP_BW:                  ok = ch_ok && (rsp_val == VW'(bw));
            STP_XC, STP_MC, STP_STAT: ok = ch_ok;
            STP_FQ:                  ok = ch_ok || (rsp_val == VW'(freq));
            STP_DIS:                 ok = ch_ok && (rsp_val != '0);
            default:                 ok = 1'b0;
        endcase
    end
endmodule

// File: rtl/rfc_cfg_seq.sv
module rfc_cfg_seq import rfc_pkg::*; #(
    parameter int FREQ_W      = 17,
    parameter int VAL_W       = 20,
    parameter int CMD_BYTES   = 10,
    parameter int FREQ_DIGITS = 5
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   op_valid,
    input  logic [1:0]             op_code,
    input  logic [BW_W-1:0]        bw_mhz,
    input  logic [FREQ_W-1:0]      freq_mhz,
    output logic                   op_ready,
    output logic                   txn_start,
    output logic [CMD_BYTES*8-1:0] txn_cmd,
    input  logic                   txn_done,
    input  logic [7:0]             rsp_char,
    input  logic [VAL_W-1:0]       rsp_val,
    output logic                   seq_done,
    output logic                   seq_pass,
    output logic [2:0]             step_idx,
    output logic [2:0]             fail_step
);
    localparam int CMD_W = CMD_BYTES * 8;
    localparam int ASC_W = FREQ_DIGITS * 8;

    fsm_e              state;
    step_e             step_q, fail_q, step_next;
    logic [BW_W-1:0]   bw_q;
    logic [FREQ_W-1:0] freq_q;
    logic              pass_q, done_q, start_q;
    logic [CMD_W-1:0]  cmd_q, cmd_d;
    logic              conv_go, conv_done, reply_ok;
    logic [FREQ_W-1:0] conv_val;
    logic [ASC_W-1:0]  conv_asc;
    opc_e              opc;

    assign opc = opc_e'(op_code);

    always_comb begin
        conv_go  = (state == FS_PREP) && ((step_q == STP_BW) || (step_q == STP_FQ));
        conv_val = (step_q == STP_BW) ? FREQ_W'(bw_q) : freq_q;
    end

    // enable chain advances on success; any enable failure jumps to status
    always_comb begin
        case (step_q)
            STP_BW:  step_next = reply_ok ? STP_XC : STP_STAT;
            STP_XC:  step_next = reply_ok ? STP_MC : STP_STAT;
            STP_MC:  step_next = reply_ok ? STP_FQ : STP_STAT;
            STP_FQ:  step_next = STP_STAT;
            default: step_next = STP_NONE;
        endcase
    end

    rfc_dec_ascii #(.VW(FREQ_W), .NDIG(FREQ_DIGITS)) u_conv (
        .clk   (clk),
        .rst   (rst),
        .start (conv_go),
        .value (conv_val),
        .done  (conv_done),
        .asc   (conv_asc)
    );

    rfc_cmd_build #(.NB(CMD_BYTES), .NDIG(FREQ_DIGITS)) u_build (
        .step (step_q),
        .asc  (conv_asc),
        .cmd  (cmd_d)
    );

    rfc_reply_judge #(.VW(VAL_W), .FW(FREQ_W)) u_judge (
        .step     (step_q),
        .rsp_char (rsp_char),
        .rsp_val  (rsp_val),
        .bw       (bw_q),
        .freq     (freq_q),
        .ok       (reply_ok)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= FS_BOOT;
            step_q  <= STP_NONE;
            fail_q  <= STP_NONE;
            bw_q    <= '0;
            freq_q  <= '0;
            pass_q  <= 1'b0;
            done_q  <= 1'b0;
            start_q <= 1'b0;
            cmd_q   <= '0;
        end else begin
            start_q <= 1'b0;
            done_q  <= 1'b0;
            case (state)
                FS_BOOT: begin
                    step_q <= STP_DIS;
                    fail_q <= STP_NONE;
                    state  <= FS_PREP;
                end
                FS_IDLE: begin
                    if (op_valid && (opc != OPC_RSVD)) begin
                        bw_q   <= bw_fix(bw_mhz);
                        freq_q <= freq_mhz;
                        fail_q <= STP_NONE;
                        pass_q <= 1'b0;
                        case (opc)
                            OPC_TUNE:   step_q <= STP_BW;
                            OPC_STATUS: step_q <= STP_STAT;
                            default:    step_q <= STP_DIS;
                        endcase
                        state <= FS_PREP;
                    end
                end
                FS_PREP:  state <= conv_go ? FS_CONV : FS_ISSUE;
                FS_CONV:  if (conv_done) state <= FS_ISSUE;
                FS_ISSUE: begin
                    cmd_q   <= cmd_d;
                    start_q <= 1'b1;
                    state   <= FS_WAIT;
                end
                FS_WAIT: begin
                    if (txn_done) begin
                        if (!reply_ok && (fail_q == STP_NONE)) fail_q <= step_q;
                        if ((step_q == STP_STAT) || (step_q == STP_DIS)) begin
                            pass_q <= (fail_q == STP_NONE) && reply_ok;
                            done_q <= 1'b1;
                            step_q <= STP_NONE;
                            state  <= FS_IDLE;
                        end else begin
                            step_q <= step_next;
                            state  <= FS_PREP;
                        end
                    end
                end
                default: state <= FS_IDLE;
            endcase
        end
    end

    assign op_ready  = (state == FS_IDLE);
    assign txn_start = start_q;
    assign txn_cmd   = cmd_q;
    assign seq_done  = done_q;
    assign seq_pass  = pass_q;
    assign step_idx  = step_q;
    assign fail_step = fail_q;

    AST_START_PULSE: assert property (@(posedge clk) disable iff (rst)
        txn_start |=> !txn_start);                                       // R9
    AST_CMD_HELD: assert property (@(posedge clk) disable iff (rst)
        (state == FS_WAIT && !txn_start) |-> $stable(txn_cmd));          // R9
    AST_PAD_ZERO: assert property (@(posedge clk) disable iff (rst)
        txn_start |-> (txn_cmd[CMD_W-1 -: 8] == 8'h00));                 // R9
    AST_NO_READY_BUSY: assert property (@(posedge clk) disable iff (rst)
        txn_start |-> !op_ready);                                        // R10
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
        seq_done |-> (op_ready && step_idx == 3'd0));                    // R11
    AST_PASS_CLEAN: assert property (@(posedge clk) disable iff (rst)
        (seq_done && seq_pass) |-> (fail_step == 3'd0));                 // R11
    AST_FAIL_CODED: assert property (@(posedge clk) disable iff (rst)
        (seq_done && !seq_pass) |-> (fail_step != 3'd0));                // R11
    AST_X_AFTER_BW: assert property (@(posedge clk) disable iff (rst)
        (step_idx == 3'd2 && $past(step_idx) != 3'd2) |-> ($past(step_idx) == 3'd1)); // R5
    AST_FQ_AFTER_M: assert property (@(posedge clk) disable iff (rst)
        (step_idx == 3'd4 && $past(step_idx) != 3'd4) |-> ($past(step_idx) == 3'd3)); // R5
    AST_WEAK_FQ: assert property (@(posedge clk) disable iff (rst)
        (state == FS_WAIT && txn_done && step_idx == 3'd4 && rsp_char == 8'h46)
        |=> (fail_step != 3'd4));                                        // R4

endmodule

// File: tb/test_rfc_cfg_seq.sv
module test_rfc_cfg_seq;
    localparam int CLK_PERIOD = 10;
    localparam int LAT        = 3;
    localparam int NVEC       = 14;

    typedef struct packed {
        logic [1:0]  op;
        logic [7:0]  bw;
        logic [16:0] freq;
        logic [7:0]  badc;
        logic [7:0]  badv;
        logic        xpass;
        logic [2:0]  xfail;
        logic [39:0] letters;
    } vec_t;

    // op: 0 tune, 1 status, 2 disable; badc/badv: letter whose reply char/value is corrupted
    localparam logic [86:0] VECS [NVEC] = '{
        {2'd0, 8'd20, 17'd5180,  8'h00, 8'h00, 1'b1, 3'd0, 40'("bxmfs")},
        {2'd0, 8'd0,  17'd2412,  8'h00, 8'h00, 1'b1, 3'd0, 40'("bxmfs")},
        {2'd0, 8'd40, 17'd5805,  "x",   8'h00, 1'b0, 3'd2, 40'("bxs")},
        {2'd0, 8'd5,  17'd100,   8'h00, "b",   1'b0, 3'd1, 40'("bs")},
        {2'd0, 8'd10, 17'd5745,  "f",   8'h00, 1'b1, 3'd0, 40'("bxmfs")},
        {2'd0, 8'd40, 17'd5500,  "f",   "f",   1'b0, 3'd4, 40'("bxmfs")},
        {2'd0, 8'd15, 17'd99999, "s",   8'h00, 1'b0, 3'd5, 40'("bxmfs")},
        {2'd1, 8'd0,  17'd0,     8'h00, 8'h00, 1'b1, 3'd0, 40'("s")},
        {2'd2, 8'd0,  17'd0,     8'h00, 8'h00, 1'b1, 3'd0, 40'("b")},
        {2'd2, 8'd0,  17'd0,     8'h00, "b",   1'b0, 3'd6, 40'("b")},
        {2'd2, 8'd0,  17'd0,     "b",   8'h00, 1'b0, 3'd6, 40'("b")},
        {2'd0, 8'd20, 17'd2437,  "m",   8'h00, 1'b0, 3'd3, 40'("bxms")},
        {2'd0, 8'd40, 17'd5200,  8'h00, "f",   1'b1, 3'd0, 40'("bxmfs")},
        {2'd0, 8'd10, 17'd5745,  "b",   8'h00, 1'b0, 3'd1, 40'("bs")}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        op_valid = 1'b0;
    logic [1:0]  op_code = 2'd0;
    logic [7:0]  bw_mhz = 8'd0;
    logic [16:0] freq_mhz = 17'd0;
    logic        op_ready, txn_start, seq_done, seq_pass;
    logic [79:0] txn_cmd;
    logic        txn_done = 1'b0;
    logic [7:0]  rsp_char = 8'h00;
    logic [19:0] rsp_val = 20'd0;
    logic [2:0]  step_idx, fail_step;

    int          n_cmp = 0;
    int          n_bad = 0;
    int          cur_op = 2;
    int          cur_bw = 0;
    int          cur_freq = 0;
    logic [7:0]  cur_badc = 8'h00;
    logic [7:0]  cur_badv = 8'h00;
    logic [7:0]  log_q [8];
    int          log_n = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rfc_cfg_seq i_rfc_cfg_seq (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
        .bw_mhz(bw_mhz), .freq_mhz(freq_mhz), .op_ready(op_ready),
        .txn_start(txn_start), .txn_cmd(txn_cmd), .txn_done(txn_done),
        .rsp_char(rsp_char), .rsp_val(rsp_val), .seq_done(seq_done),
        .seq_pass(seq_pass), .step_idx(step_idx), .fail_step(fail_step)
    );

    task automatic check_eq(string req, string what, longint act, longint exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic report();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    function automatic int bw_rule(int b);
        return (b == 5 || b == 10 || b == 20 || b == 40) ? b : 20;
    endfunction

    function automatic logic [79:0] exp_cmd(logic [7:0] l);
        string s;
        logic [79:0] r;
        if (l == "b") s = (cur_op == 2) ? "b40" : $sformatf("b%02d", bw_rule(cur_bw));
        else if (l == "f") s = $sformatf("f%05d", cur_freq);
        else s = $sformatf("%c", l);
        r = '0;
        for (int i = 0; i < s.len(); i++) r[8*i +: 8] = s[i];
        return r;
    endfunction

    function automatic int exp_step(logic [7:0] l);
        case (l)
            "b":     return (cur_op == 2) ? 6 : 1;
            "x":     return 2;
            "m":     return 3;
            "f":     return 4;
            "s":     return 5;
            default: return 0;
        endcase
    endfunction

    // transaction engine model: echoes the command, optionally corrupted
    initial begin
        forever begin
            @(negedge clk);
            if (txn_start) begin
                logic [7:0] l;
                int v;
                l = txn_cmd[7:0];
                if (log_n < 8) log_q[log_n] = l;
                log_n++;
                check_eq("R9 R1 R2 R4 R6", $sformatf("command buffer for '%c' (hex)", l), 1,
                         (txn_cmd == exp_cmd(l)) ? 1 : 0);
                if (txn_cmd != exp_cmd(l))
                    $display("FAIL R9 buffer actual %h expected %h", txn_cmd, exp_cmd(l));
                check_eq("R11", "step_idx during transaction", step_idx, exp_step(l));
                if (l == "b") v = (cur_op == 2) ? 40 : bw_rule(cur_bw);
                else if (l == "f") v = cur_freq;
                else v = 0;
                repeat (LAT) @(negedge clk);
                rsp_char = (l == cur_badc) ? "?" : (l - 8'h20);
                rsp_val  = (l == cur_badv) ? 20'd0 : 20'(v);
                txn_done = 1'b1;
                @(negedge clk);
                txn_done = 1'b0;
            end
        end
    end

    task automatic wait_done(output bit seen);
        seen = 0;
        for (int k = 0; k < 3000; k++) begin
            @(negedge clk);
            if (seq_done) begin seen = 1; break; end
        end
    endtask

    task automatic check_log(string req, logic [39:0] letters);
        int n;
        n = 0;
        for (int b = 4; b >= 0; b--) begin
            if (letters[8*b +: 8] != 8'h00) begin
                if (n < log_n && n < 8)
                    check_eq(req, $sformatf("command %0d letter", n), log_q[n], letters[8*b +: 8]);
                n++;
            end
        end
        check_eq(req, "number of commands issued", log_n, n);
    endtask

    task automatic run_op(int op, int bw, int fq, logic [7:0] bc, logic [7:0] bv, bit poke);
        cur_op = op; cur_bw = bw; cur_freq = fq; cur_badc = bc; cur_badv = bv;
        log_n = 0;
        @(negedge clk);
        op_valid = 1'b1; op_code = 2'(op); bw_mhz = 8'(bw); freq_mhz = 17'(fq);
        @(negedge clk);
        op_valid = 1'b0;
        if (poke) begin
            repeat (4) @(negedge clk);
            op_valid = 1'b1; op_code = 2'd1;
            @(negedge clk);
            op_valid = 1'b0;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        bit seen;
        vec_t v;
        // reset state
        repeat (3) @(negedge clk);
        check_eq("R8", "op_ready in reset", op_ready, 0);
        check_eq("R9", "txn_start in reset", txn_start, 0);
        check_eq("R11", "seq_done in reset", seq_done, 0);
        check_eq("R11", "step_idx in reset", step_idx, 0);
        check_eq("R11", "fail_step in reset", fail_step, 0);
        cur_op = 2; log_n = 0;
        rst = 1'b0;
        @(negedge clk);
        check_eq("R8", "op_ready during boot disable", op_ready, 0);
        wait_done(seen);
        check_eq("R8", "boot disable completes", seen, 1);
        check_eq("R8 R6", "boot disable pass", seq_pass, 1);
        check_log("R8 R6", 40'("b"));

        // table walk
        for (int i = 0; i < NVEC; i++) begin
            v = vec_t'(VECS[i]);
            run_op(int'(v.op), int'(v.bw), int'(v.freq), v.badc, v.badv, 1'b0);
            wait_done(seen);
            check_eq("R11", $sformatf("vec %0d done", i), seen, 1);
            check_eq("R11 R2 R3 R4 R6 R7", $sformatf("vec %0d pass", i), seq_pass, v.xpass);
            check_eq("R11 R5", $sformatf("vec %0d fail_step", i), fail_step, v.xfail);
            check_log("R5 R3 R7", v.letters);
            repeat (3) @(negedge clk);
        end

        // R10: request while busy is ignored
        run_op(0, 40, 5320, 8'h00, 8'h00, 1'b1);
        wait_done(seen);
        check_eq("R10", "busy-time request ignored, pass", seq_pass, 1);
        check_log("R10", 40'("bxmfs"));
        repeat (30) @(negedge clk);
        check_eq("R10", "no commands after busy request", log_n, 5);

        // R10: reserved code ignored
        log_n = 0;
        @(negedge clk);
        op_valid = 1'b1; op_code = 2'd3;
        @(negedge clk);
        op_valid = 1'b0;
        repeat (30) @(negedge clk);
        check_eq("R10", "reserved code issues no command", log_n, 0);
        check_eq("R10", "reserved code leaves block idle", op_ready, 1);
        report();
    end
endmodule